// File: doc/BRIEF.md
# DDR Burst-of-Two SRAM Core

This block is a small synchronous static RAM whose common data path moves two words per transaction. A single clock runs at twice the command rate. An internal phase flag splits it into command slots and complement slots. Commands (load strobe, read select, address) are sampled only in command slots. Write data and byte enables arrive in the command slot and then the complement slot that follow the write command. Read data leaves in the complement slot and then the command slot after that.

Every burst starts at the addressed word and continues at the word whose address differs only in the low bit. A new command may be given in every command slot, in any mix of reads, writes and no-operations, so the data path can stay busy without gaps. There is no back-pressure: each command is accepted in the slot where it is sampled, and a consumer must take read data in the slot where the output-enable flag is high. The output-enable flag replaces a tri-state pad. The free-running echo clock follows the phase flag and tells the surrounding logic which slot is next.

Top module: `ddr2w_sram`

## Requirements
- R1: Commands are sampled only on command edges, which are clock edges where `echo_clk` was high just before the edge. `cmd_load_n` low with `cmd_rd` high starts a read, and `cmd_load_n` low with `cmd_rd` low starts a write. `cmd_load_n` high is a no-operation that ignores the address. Control inputs at complement edges are ignored.
- R2: A burst touches the addressed word first and then the word with the low address bit inverted (0 then 1, or 1 then 0).
- R3: Write data for a command sampled at edge E is taken at edge E+2 (first word) and edge E+3 (second word). Data at any other edge is ignored.
- R4: Byte enables `byte_wen_n` are active low and are sampled with each write word separately. A lane whose bit is 1 keeps its old contents. Lane l covers bits [9l+8:9l] for 18- and 36-bit words, and bits [4l+3:4l] for 8-bit words. With the default 18-bit word, bit 0 covers bits 8:0 and bit 1 covers bits 17:9.
- R5: For a read sampled at edge E, the first word is on `rdata` after edge E+3 and the second word after edge E+4.
- R6: `rd_oe` is high exactly in the two slots that carry read data. It falls one command cycle after the last read when a no-operation or write follows, and `rdata` holds while `rd_oe` stays low.
- R7: Back-to-back commands are accepted in every command slot. Consecutive reads give gap-free output.
- R8: `echo_clk` toggles on every clock edge, including while `rd_oe` is low. It is high when the next edge is a command edge.
- R9: A read returns the data of every write sampled at an earlier command edge, including a write in the command slot just before it.
- R10: While reset is asserted, `rd_oe` is low, `echo_clk` is high and no transaction is outstanding. The first edge after release is a command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load_n | input | 1 | Active-low load strobe |
| cmd_rd | input | 1 | 1 = read, 0 = write when loading |
| addr | input | ADDR_W | Word address of the first word |
| byte_wen_n | input | LANES | Active-low lane write enables, one set per write word |
| wdata | input | DATA_W | Write data word |
| rdata | output | DATA_W | Read data word |
| rd_oe | output | 1 | High when `rdata` carries a read word |
| echo_clk | output | 1 | Free-running echo of the slot phase |

## Verification
The properties assume that reset is released so that the first following edge is a command edge. They also assume that inputs carry no unknown values at sampled edges. The checks that trace a read word back to its load expect a stable command at the command edge four edges earlier. The bench aligns every command to a negative edge where `echo_clk` is high, so commands always fall in command slots. It fills complement slots with random control values and random data, and drives random data in any slot that has no write pending, so the block must reject all of them.

// File: rtl/ddr2w_pkg.sv
package ddr2w_pkg;
  // Lane width by word width: nibble lanes for narrow words, 9-bit lanes otherwise.
  function automatic int lane_w(input int data_w);
    return (data_w == 8) ? 4 : 9;
  endfunction
endpackage

// File: rtl/ddr2w_store.sv
module ddr2w_store #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wen_n,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !wen_n[l]) cells[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/ddr2w_seq.sv
module ddr2w_seq #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load_n,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_slot,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] raddr
);
  // Command captured at the last command edge
  logic              cap_v, cap_rd;
  logic [ADDR_W-1:0] cap_a;
  // Second write word pending for the complement edge
  logic              wb_v;
  logic [ADDR_W-1:0] wb_a;
  // First read word pending for the complement edge
  logic              r0_v;
  logic [ADDR_W-1:0] r0_a;
  // Second read word pending for the command edge
  logic              r1_v;
  logic [ADDR_W-1:0] r1_a;

  function automatic logic [ADDR_W-1:0] partner(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:1], ~a[0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_slot <= 1'b1;
      cap_v    <= 1'b0;
      cap_rd   <= 1'b0;
      cap_a    <= '0;
      wb_v     <= 1'b0;
      wb_a     <= '0;
      r0_v     <= 1'b0;
      r0_a     <= '0;
      r1_v     <= 1'b0;
      r1_a     <= '0;
    end else begin
      cmd_slot <= ~cmd_slot;
      if (cmd_slot) begin
        cap_v <= ~cmd_load_n;
        if (!cmd_load_n) begin
          cap_rd <= cmd_rd;
          cap_a  <= addr;
        end
        wb_v <= cap_v & ~cap_rd;
        wb_a <= partner(cap_a);
        r0_v <= cap_v & cap_rd;
        r0_a <= cap_a;
      end else begin
        r1_v <= r0_v;
        r1_a <= partner(r0_a);
      end
    end
  end

  always_comb begin
    if (cmd_slot) begin
      we      = cap_v & ~cap_rd;
      waddr   = cap_a;
      rd_fire = r1_v;
      raddr   = r1_a;
    end else begin
      we      = wb_v;
      waddr   = wb_a;
      rd_fire = r0_v;
      raddr   = r0_a;
    end
  end
endmodule

// File: rtl/ddr2w_outreg.sv
module ddr2w_outreg #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      rd_oe <= 1'b0;
    end else begin
      rd_oe <= rd_fire;
      if (rd_fire) rdata <= word;
    end
  end
endmodule

// File: rtl/ddr2w_sram.sv
module ddr2w_sram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6,
  localparam int LANE_W = ddr2w_pkg::lane_w(DATA_W),
  localparam int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load_n,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_wen_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_oe,
  output logic              echo_clk
);
  logic              cmd_slot, we, rd_fire;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] store_q;

  ddr2w_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_load_n(cmd_load_n), .cmd_rd(cmd_rd),
    .addr(addr), .cmd_slot(cmd_slot), .we(we), .waddr(waddr),
    .rd_fire(rd_fire), .raddr(raddr)
  );

  ddr2w_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .wen_n(byte_wen_n),
    .raddr(raddr), .rdata(store_q)
  );

  ddr2w_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .word(store_q),
    .rdata(rdata), .rd_oe(rd_oe)
  );

  assign echo_clk = cmd_slot;
endmodule

// File: rtl/ddr2w_sram_chk.sv
module ddr2w_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_load_n,
  input logic              cmd_rd,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_oe,
  input logic              echo_clk
);
  // R8: echo clock changes on every edge
  p_echo_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (echo_clk != $past(echo_clk)));

  // R5: output enable only rises in the first-word slot
  p_oe_rise_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> echo_clk);

  // R6: a first word is always followed by a second word
  p_oe_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && echo_clk) |=> rd_oe);

  // R1: every first word traces back to a read load four edges earlier
  p_read_from_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && echo_clk) |-> $past(!cmd_load_n && cmd_rd && echo_clk, 4));

  // R6: read data holds while the output is disabled
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_oe && !$past(rd_oe)) |-> $stable(rdata));
endmodule

bind ddr2w_sram ddr2w_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_load_n(cmd_load_n), .cmd_rd(cmd_rd),
  .rdata(rdata), .rd_oe(rd_oe), .echo_clk(echo_clk)
);

// File: tb/ddr2w_sram_tb.sv
`timescale 1ns/1ps
module ddr2w_sram_tb;
  localparam int DW = 18, AW = 6, NL = 2, LW = 9, DEPTH = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, cmd_load_n, cmd_rd, rd_oe, echo_clk;
  logic [AW-1:0] addr;
  logic [NL-1:0] byte_wen_n;
  logic [DW-1:0] wdata, rdata;

  ddr2w_sram #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_load_n(cmd_load_n), .cmd_rd(cmd_rd),
    .addr(addr), .byte_wen_n(byte_wen_n), .wdata(wdata), .rdata(rdata),
    .rd_oe(rd_oe), .echo_clk(echo_clk)
  );

  typedef struct { logic [DW-1:0] d; int unsigned cyc; logic [AW-1:0] a; } exp_t;
  exp_t          q[$];
  logic [DW-1:0] ref_mem [DEPTH];
  int            errors = 0, checks = 0;
  int unsigned   cyc = 0;
  bit            mon_en = 0, done = 0;
  logic          prev_echo;
  // pending write beats
  bit            pv = 0;
  logic [AW-1:0] pa;
  logic [DW-1:0] pd0, pd1;
  logic [NL-1:0] pm0, pm1;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [NL-1:0] m_n);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NL; l++) if (!m_n[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] a);
    return {a[AW-1:1], ~a[0]};
  endfunction

  // Called at a negedge where the next posedge is a command edge.
  task automatic issue(input bit ld, input bit rd, input logic [AW-1:0] a,
                       input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                       input logic [NL-1:0] m0, input logic [NL-1:0] m1);
    logic [DW-1:0] b0d, b1d;
    logic [NL-1:0] b0m, b1m;
    chk(echo_clk == 1'b1, "R8 command slot phase", DW'(echo_clk), DW'(1));
    b0d = pv ? pd0 : DW'($urandom);
    b0m = pv ? pm0 : NL'($urandom);
    b1d = pv ? pd1 : DW'($urandom);
    b1m = pv ? pm1 : NL'($urandom);
    if (pv) begin
      ref_mem[pa]       = merge(ref_mem[pa], pd0, pm0);
      ref_mem[flip(pa)] = merge(ref_mem[flip(pa)], pd1, pm1);
    end
    if (ld && rd) begin
      q.push_back('{d: ref_mem[a],       cyc: cyc + 4, a: a});
      q.push_back('{d: ref_mem[flip(a)], cyc: cyc + 5, a: flip(a)});
    end
    cmd_load_n = !ld; cmd_rd = rd; addr = ld ? a : AW'($urandom);
    wdata = b0d; byte_wen_n = b0m;
    @(negedge clk);
    // complement slot: random control must be ignored (R1)
    cmd_load_n = 1'($urandom); cmd_rd = 1'($urandom); addr = AW'($urandom);
    wdata = b1d; byte_wen_n = b1m;
    @(negedge clk);
    pv = ld && !rd; pa = a; pd0 = d0; pd1 = d1; pm0 = m0; pm1 = m1;
  endtask

  task automatic nop();
    issue(0, 0, '0, '0, '0, '1, '1);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mon_en && !done) begin
      chk(echo_clk != prev_echo, "R8 echo toggles", DW'(echo_clk), DW'(!prev_echo));
      if (q.size() > 0 && q[0].cyc == cyc) begin
        if (!rd_oe) chk(0, "R5 R6 rd_oe missing for read word", DW'(rd_oe), DW'(1));
        else chk(rdata == q[0].d, $sformatf("R2 R4 R5 R9 read word addr %0d", q[0].a), rdata, q[0].d);
        void'(q.pop_front());
      end else if (rd_oe) begin
        chk(0, "R6 R1 unexpected rd_oe", DW'(rd_oe), DW'(0));
      end
    end
    prev_echo = echo_clk;
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; cmd_load_n = 1; cmd_rd = 0; addr = '0; byte_wen_n = '1; wdata = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(rd_oe == 1'b0, "R10 rd_oe low in reset", DW'(rd_oe), DW'(0));
    chk(echo_clk == 1'b1, "R10 echo_clk high in reset", DW'(echo_clk), DW'(1));
    rst_n = 1;
    prev_echo = 1'b0;
    mon_en = 1;

    // R3: fill the array with full-lane bursts at even addresses
    for (int i = 0; i < DEPTH / 2; i++)
      issue(1, 0, AW'(2 * i), DW'($urandom), DW'($urandom), '0, '0);
    // R2 R5 R7: read every address back to back, odd and even starts
    for (int i = 0; i < DEPTH; i++) issue(1, 1, AW'(i), '0, '0, '1, '1);
    // R6: no-operations with random addresses, output must go quiet
    repeat (4) nop();
    chk(rd_oe == 1'b0, "R6 rd_oe low after no-operations", DW'(rd_oe), DW'(0));

    // R4: per-word lane masks, odd start address
    issue(1, 0, 6'd5, 18'h2A5A5, 18'h15A5A, 2'b10, 2'b01);
    issue(1, 1, 6'd5, '0, '0, '1, '1);
    issue(1, 1, 6'd4, '0, '0, '1, '1);
    issue(1, 0, 6'd9, 18'h3FFFF, 18'h3FFFF, 2'b11, 2'b11);  // R4: write nothing
    issue(1, 1, 6'd8, '0, '0, '1, '1);

    // R9: read right after a write to the same burst
    issue(1, 0, 6'd20, 18'h12345, 18'h0ABCD, '0, '0);
    issue(1, 1, 6'd20, '0, '0, '1, '1);
    issue(1, 0, 6'd33, 18'h00F0F, 18'h3C3C3, '0, 2'b01);
    issue(1, 1, 6'd32, '0, '0, '1, '1);

    // R7: random mix in every command slot
    for (int i = 0; i < 400; i++) begin
      int unsigned k = $urandom % 4;
      issue(k != 0, k >= 2, AW'($urandom), DW'($urandom), DW'($urandom), NL'($urandom), NL'($urandom));
    end

    repeat (4) nop();
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R7 every read produced its words", DW'(q.size()), DW'(0));
    chk(rd_oe == 1'b0, "R6 rd_oe low at end", DW'(rd_oe), DW'(0));
    finish_run();
  end
endmodule